// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block lets several processors pass 32-bit messages to one another through a bank of small hardware queues. All of them sit behind one word-addressed register bus. A sender writes a word to a queue's message port. A receiver reads the same port and gets the oldest word back. Each queue also exposes a full flag and a count of pending words.

Every processor, called a user, owns its own set of three registers: an event status register, an enable-set register and an enable-clear register. Each queue raises two events, one for a newly arrived message and one for space freed in a queue that was full. Every user sees both events and masks them for itself. A user's interrupt line is high while any event in its status register is both pending and enabled. The bus has one address, separate write and read strobes, and read data that is registered one cycle after the read strobe.

Top module: `mailbox_hub`

## Requirements
- R1: After reset every queue is empty, every status and enable register is zero, every interrupt is low and read data is zero.
- R2: A read at offset 0x000 returns the revision constant. Writes there change nothing.
- R3: A write to offset 0x040+4·m appends the word to queue m. A read there removes and returns the oldest word. Read data appears on the cycle after the read strobe and holds until the next read.
- R4: Offset 0x080+4·m reads 1 when queue m holds DEPTH words and 0 otherwise. Offset 0x0C0+4·m reads its word count.
- R5: A write to a full queue is dropped and leaves its contents and count unchanged.
- R6: A read from an empty queue returns zero and leaves the queue unchanged.
- R7: An accepted write to queue m sets bit 2·m in the status register of every user.
- R8: A read that takes queue m from full to not full sets bit 2·m+1 in the status register of every user.
- R9: For user u, the status register sits at 0x104+0x10·u. Writing 1 to a bit there clears it, writing 0 leaves it as is, and bits above 2·NQ−1 read zero.
- R10: For user u, writing 1s at 0x108+0x10·u sets enable bits and writing 1s at 0x10C+0x10·u clears them. Both offsets read the current enable mask.
- R11: irq[u] is high exactly when the status AND enable of user u is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; pops a queue when addressing its message port |
| rd_data | output | 32 | Registered read data |
| irq | output | NU | One interrupt line per user |

## Verification
The bench builds the block with its defaults: eight queues of four words each and four users. A depth of four lets random traffic reach the full and empty edges of a queue within a few operations, so both dropped writes and zero-returning reads occur often. Eight queues fill a 16-bit event field, so the random clear and enable words that also drive the upper half show that those bits have no effect. Four users show that one queue's events land in every user's status register while each user's mask stays separate.

// File: rtl/mailbox_hub.sv
module mailbox_hub #(
  parameter int NQ = 8,
  parameter int DEPTH = 4,
  parameter int NU = 4,
  parameter int AW = 9,
  parameter logic [31:0] REV = 32'h0002_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic [NU-1:0] irq
);
  localparam int PW = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 2 * NQ;

  logic [31:0]   mem [NQ][DEPTH];
  logic [PW-1:0] wp [NQ];
  logic [PW-1:0] rp [NQ];
  logic [CW-1:0] cnt [NQ];
  logic [NQ-1:0] sel_msg, push, pop;
  logic [EW-1:0] ev;
  logic [EW-1:0] sts [NU];
  logic [EW-1:0] ena [NU];
  logic [NU-1:0] sel_sts, sel_set, sel_clr;
  logic [31:0]   rnext;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign sel_msg[q] = addr == AW'(12'h040 + 4 * q);
    assign push[q]    = wr_en && sel_msg[q] && cnt[q] != CW'(DEPTH);
    assign pop[q]     = rd_en && sel_msg[q] && cnt[q] != '0;
    assign ev[2*q]    = push[q];
    assign ev[2*q+1]  = pop[q] && cnt[q] == CW'(DEPTH);

    always_ff @(posedge clk)
      if (push[q]) mem[q][wp[q]] <= wr_data;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp[q]  <= '0;
        rp[q]  <= '0;
        cnt[q] <= '0;
      end else begin
        if (push[q]) wp[q] <= (wp[q] == PW'(DEPTH - 1)) ? '0 : wp[q] + 1'b1;
        if (pop[q])  rp[q] <= (rp[q] == PW'(DEPTH - 1)) ? '0 : rp[q] + 1'b1;
        cnt[q] <= cnt[q] + CW'(push[q]) - CW'(pop[q]);
      end
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_u
    assign sel_sts[u] = addr == AW'(12'h104 + 16 * u);
    assign sel_set[u] = addr == AW'(12'h108 + 16 * u);
    assign sel_clr[u] = addr == AW'(12'h10C + 16 * u);
    assign irq[u]     = |(sts[u] & ena[u]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sts[u] <= '0;
        ena[u] <= '0;
      end else begin
        sts[u] <= (sts[u] & ~((wr_en && sel_sts[u]) ? wr_data[EW-1:0] : '0)) | ev;
        if (wr_en && sel_set[u])      ena[u] <= ena[u] | wr_data[EW-1:0];
        else if (wr_en && sel_clr[u]) ena[u] <= ena[u] & ~wr_data[EW-1:0];
      end
    end
  end

  always_comb begin
    rnext = '0;
    if (addr == '0) rnext = REV;
    for (int q = 0; q < NQ; q++) begin
      if (sel_msg[q] && cnt[q] != '0) rnext = mem[q][rp[q]];
      if (addr == AW'(12'h080 + 4 * q)) rnext = {31'b0, cnt[q] == CW'(DEPTH)};
      if (addr == AW'(12'h0C0 + 4 * q)) rnext = 32'(cnt[q]);
    end
    for (int u = 0; u < NU; u++) begin
      if (sel_sts[u]) rnext = 32'(sts[u]);
      if (sel_set[u] || sel_clr[u]) rnext = 32'(ena[u]);
    end
  end

  always_ff @(posedge clk)
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rnext;
endmodule

// File: rtl/mailbox_hub_chk.sv
module mailbox_hub_chk #(
  parameter int NQ = 8,
  parameter int DEPTH = 4,
  parameter int NU = 4,
  parameter int AW = 9,
  parameter int CW = $clog2(DEPTH + 1),
  parameter int EW = 2 * NQ
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [31:0]   rd_data,
  input logic [NU-1:0] irq,
  input logic [CW-1:0] cnt [NQ],
  input logic [EW-1:0] sts [NU],
  input logic [EW-1:0] ena [NU]
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic hit;
    assign hit = addr == AW'(12'h040 + 4 * q);

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[q] <= CW'(DEPTH));
    p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !rd_en && hit && cnt[q] == CW'(DEPTH) |=> cnt[q] == CW'(DEPTH));
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !wr_en && hit && cnt[q] == '0 |=> rd_data == '0 && cnt[q] == '0);

    for (genvar u = 0; u < NU; u++) begin : g_u
      p_newmsg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && hit && cnt[q] != CW'(DEPTH) |=> sts[u][2*q]);
      p_notfull_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && hit && cnt[q] == CW'(DEPTH) |=> sts[u][2*q+1]);
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_irq
    p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ena[u] == '0 |-> !irq[u]);
    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq[u] |-> sts[u] != '0);
  end
endmodule

bind mailbox_hub mailbox_hub_chk #(.NQ(NQ), .DEPTH(DEPTH), .NU(NU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .irq(irq), .cnt(cnt), .sts(sts), .ena(ena)
);

// File: tb/mailbox_hub_test.sv
`timescale 1ns/1ps
module mailbox_hub_test;
  localparam int NQ = 8, DEPTH = 4, NU = 4, AW = 9;
  localparam logic [31:0] REV = 32'h0002_0100;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NU-1:0] irq;
  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] bm [NQ][DEPTH];
  int bc [NQ];
  logic [15:0] ms [NU];
  logic [15:0] me [NU];

  always #2.5 clk = ~clk;

  mailbox_hub #(.NQ(NQ), .DEPTH(DEPTH), .NU(NU), .AW(AW), .REV(REV)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [NU-1:0] exp_irq();
    logic [NU-1:0] v;
    for (int u = 0; u < NU; u++) v[u] = |(ms[u] & me[u]);
    return v;
  endfunction

  task automatic m_write(logic [AW-1:0] a, logic [31:0] d);
    for (int q = 0; q < NQ; q++)
      if (a == AW'(12'h040 + 4 * q) && bc[q] < DEPTH) begin
        bm[q][bc[q]] = d; bc[q]++;
        for (int u = 0; u < NU; u++) ms[u][2*q] = 1'b1;
      end
    for (int u = 0; u < NU; u++) begin
      if (a == AW'(12'h104 + 16 * u)) ms[u] &= ~d[15:0];
      if (a == AW'(12'h108 + 16 * u)) me[u] |= d[15:0];
      if (a == AW'(12'h10C + 16 * u)) me[u] &= ~d[15:0];
    end
  endtask

  task automatic m_read(logic [AW-1:0] a, output logic [31:0] e, output string tag);
    e = '0; tag = "R2";
    for (int q = 0; q < NQ; q++) begin
      if (a == AW'(12'h040 + 4 * q)) begin
        tag = bc[q] == 0 ? "R6" : "R3";
        if (bc[q] > 0) begin
          if (bc[q] == DEPTH) for (int u = 0; u < NU; u++) ms[u][2*q+1] = 1'b1;
          e = bm[q][0];
          for (int i = 0; i < DEPTH - 1; i++) bm[q][i] = bm[q][i+1];
          bc[q]--;
        end
      end
      if (a == AW'(12'h080 + 4 * q)) begin e = 32'(bc[q] == DEPTH); tag = "R4"; end
      if (a == AW'(12'h0C0 + 4 * q)) begin e = 32'(bc[q]); tag = "R4"; end
    end
    for (int u = 0; u < NU; u++) begin
      if (a == AW'(12'h104 + 16 * u)) begin e = 32'(ms[u]); tag = "R9"; end
      if (a == AW'(12'h108 + 16 * u) || a == AW'(12'h10C + 16 * u)) begin
        e = 32'(me[u]); tag = "R10";
      end
    end
    if (a == '0) e = REV;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    m_write(a, d);
    check("R11 irq", 32'(irq), 32'(exp_irq()));
  endtask

  task automatic rd(logic [AW-1:0] a);
    logic [31:0] e; string tag;
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
    m_read(a, e, tag);
    check(tag, rd_data, e);
    check("R11 irq", 32'(irq), 32'(exp_irq()));
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(20240611);
    for (int q = 0; q < NQ; q++) bc[q] = 0;
    for (int u = 0; u < NU; u++) begin ms[u] = '0; me[u] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(9'h0C4);
    rd(9'h104);
    rd(9'h13C);
    rd(9'h000);
    wr(9'h000, 32'hFFFF_FFFF);
    rd(9'h000);
    // R5, R7, R8: fill queue 3 with user 2 watching
    wr(9'h128, 32'h0000_00C0);
    for (int i = 0; i < 5; i++) wr(9'h04C, 32'hA000_0000 + i);
    rd(9'h08C);
    rd(9'h0CC);
    rd(9'h124);
    wr(9'h124, 32'h0000_0040);
    rd(9'h124);
    for (int i = 0; i < 5; i++) rd(9'h04C);
    rd(9'h08C);
    rd(9'h104);
    wr(9'h124, 32'h0000_0000);
    rd(9'h124);
    wr(9'h12C, 32'hFFFF_FFFF);
    rd(9'h128);
    // random traffic
    for (int n = 0; n < 600; n++) begin
      int k, q, u;
      k = $urandom % 10; q = $urandom % NQ; u = $urandom % NU;
      case (k)
        0, 1, 2: wr(AW'(12'h040 + 4 * q), $urandom);
        3, 4:    rd(AW'(12'h040 + 4 * q));
        5:       rd(AW'(($urandom % 2) ? 12'h080 + 4 * q : 12'h0C0 + 4 * q));
        6:       rd(AW'(12'h104 + 16 * u + 4 * ($urandom % 3)));
        7:       wr(AW'(12'h104 + 16 * u), $urandom);
        8:       wr(AW'(12'h108 + 16 * u), $urandom);
        default: wr(AW'(12'h10C + 16 * u), $urandom & $urandom);
      endcase
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule